// File: doc/BRIEF.md
# Eight-Phase Accumulator Processor

This block is a minimal 8-bit accumulator machine that completes one instruction every eight clocks. A three-bit phase counter steps in Gray-code order. Each phase decodes to a fixed set of strobes that drive an external synchronous memory and the internal register loads. The block holds a program counter, an instruction register, an operand latch and an accumulator. A small ALU combines the accumulator with the latched memory operand.

The external memory is expected to return read data combinationally for the address presented. It writes on the rising clock edge that ends a cycle in which the write strobe is high. An instruction word holds a 3-bit opcode in bits 7:5 and a 5-bit operand address in bits 4:0. The machine supports no-op, increment, add, complement, XOR, load, store and unconditional jump.

Top module: `ocp_core`

## Requirements
- R1: The phase register advances once per clock in the order 000, 001, 011, 010, 110, 111, 101, 100 and then returns to 000, so every instruction takes exactly eight clocks.
- R2: While reset is low, the phase is 000, the program counter is 00h and the accumulator is 00h. Memory address is 00h, both strobes are low and the zero flag is high.
- R3: In phase 001 the read strobe is high and the address equals the program counter. The word read is latched into the instruction register: opcode in bits 7:5, operand address in bits 4:0.
- R4: The read strobe is high only in phase 001 and, for opcodes 2, 4 and 5, in phase 111. It is low in phase 011. Read and write are never high together.
- R5: The program counter increments by one in phase 010 only, wrapping from 1Fh to 00h. It is otherwise unchanged, except for a jump.
- R6: In phases 110, 111, 101 and 100 the memory address is the instruction's operand field. In all other phases it is the program counter.
- R7: The accumulator changes only at the end of phase 101. Opcode 1 adds one, opcode 2 adds the memory operand, opcode 3 inverts all bits, opcode 4 XORs with the memory operand and opcode 5 loads the operand. Opcodes 0, 6 and 7 leave it unchanged. All arithmetic wraps modulo 256.
- R8: Opcode 7 loads the operand address into the program counter at the end of phase 111, so the next fetch is from that address.
- R9: Opcode 6 raises the write strobe in phase 100 only, with the accumulator on the write-data bus and the operand field on the address bus. Write data is 00h whenever the write strobe is low.
- R10: The zero output is high exactly when the accumulator is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 5 | Memory address (PC or operand field) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid combinationally for mem_addr |
| acc_out | output | 8 | Accumulator value |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
A phase counter that skips or repeats a state shows up at once at the ports. The fetch strobe then appears at the wrong offset within the eight-clock frame, and the operand address shows on the bus too early or too late. A program counter that is stale, double-stepped or loaded wrongly by a jump shows up at the next fetch, at most eight clocks later, as a wrong address. A wrong ALU result or stray accumulator load becomes visible on the accumulator output one clock after phase 101. A faulty store shows up in the write cycle of that instruction as a wrong strobe, address or data value.

// File: rtl/ocp_pkg.sv
`timescale 1ns/1ps
package ocp_pkg;

    localparam int unsigned OP_W    = 3;
    localparam int unsigned PHASE_W = 3;

    // Gray-ordered phases of one instruction frame
    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE  = 3'b000,
        PH_FETCH = 3'b001,
        PH_HOLD  = 3'b011,
        PH_STEP  = 3'b010,
        PH_ADDR  = 3'b110,
        PH_OPRD  = 3'b111,
        PH_EXEC  = 3'b101,
        PH_WRB   = 3'b100
    } phase_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 3'd0,
        OP_INC = 3'd1,
        OP_ADD = 3'd2,
        OP_NOT = 3'd3,
        OP_XOR = 3'd4,
        OP_LDA = 3'd5,
        OP_STA = 3'd6,
        OP_JMP = 3'd7
    } opcode_e;

    typedef struct packed {
        logic rd;       // memory read strobe
        logic wr;       // memory write strobe
        logic ir_ld;    // capture instruction word
        logic pc_inc;   // advance program counter
        logic pc_ld;    // load program counter from operand field
        logic opnd_ld;  // capture memory operand
        logic acc_ld;   // write ALU result to accumulator
        logic sel_ir;   // address from operand field
    } ctrl_t;

endpackage

// File: rtl/ocp_sequencer.sv
`timescale 1ns/1ps
module ocp_sequencer
    import ocp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    output phase_e  phase_q,
    output ctrl_t   ctrl
);

    phase_e phase_d;

    always_comb begin
        phase_d = PH_IDLE;
        ctrl    = '0;
        unique case (phase_q)
            PH_IDLE:  phase_d = PH_FETCH;
            PH_FETCH: begin
                phase_d    = PH_HOLD;
                ctrl.rd    = 1'b1;
                ctrl.ir_ld = 1'b1;
            end
            PH_HOLD:  phase_d = PH_STEP;
            PH_STEP: begin
                phase_d     = PH_ADDR;
                ctrl.pc_inc = 1'b1;
            end
            PH_ADDR: begin
                phase_d     = PH_OPRD;
                ctrl.sel_ir = 1'b1;
            end
            PH_OPRD: begin
                phase_d     = PH_EXEC;
                ctrl.sel_ir = 1'b1;
                if (op == OP_ADD || op == OP_XOR || op == OP_LDA) begin
                    ctrl.rd      = 1'b1;
                    ctrl.opnd_ld = 1'b1;
                end
                if (op == OP_JMP) ctrl.pc_ld = 1'b1;
            end
            PH_EXEC: begin
                phase_d     = PH_WRB;
                ctrl.sel_ir = 1'b1;
                ctrl.acc_ld = (op == OP_INC) || (op == OP_ADD) || (op == OP_NOT)
                           || (op == OP_XOR) || (op == OP_LDA);
            end
            PH_WRB: begin
                phase_d     = PH_IDLE;
                ctrl.sel_ir = 1'b1;
                ctrl.wr     = (op == OP_STA);
            end
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/ocp_alu.sv
`timescale 1ns/1ps
module ocp_alu
    import ocp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_INC:  res = acc + DATA_W'(1);
            OP_ADD:  res = acc + opnd;
            OP_NOT:  res = ~acc;
            OP_XOR:  res = acc ^ opnd;
            OP_LDA:  res = opnd;
            default: res = acc;
        endcase
    end

endmodule

// File: rtl/ocp_core.sv
`timescale 1ns/1ps
module ocp_core
    import ocp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5   // DATA_W must equal ADDR_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_zero
);

    localparam int unsigned OP_LSB = DATA_W - OP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] acc;
    } dp_t;

    dp_t st_d, st_q;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_res;
    opcode_e           op;
    phase_e            phase_q;
    ctrl_t             ctrl;

    assign pc_q  = st_q.pc;
    assign ir_q  = st_q.ir;
    assign acc_q = st_q.acc;
    assign op    = opcode_e'(ir_q[DATA_W-1:OP_LSB]);

    ocp_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .phase_q (phase_q),
        .ctrl    (ctrl)
    );

    ocp_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (op),
        .acc  (acc_q),
        .opnd (st_q.opnd),
        .res  (alu_res)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl.ir_ld)   st_d.ir   = mem_rdata;
        if (ctrl.pc_inc)  st_d.pc   = pc_q + ADDR_W'(1);
        if (ctrl.pc_ld)   st_d.pc   = ir_q[ADDR_W-1:0];
        if (ctrl.opnd_ld) st_d.opnd = mem_rdata;
        if (ctrl.acc_ld)  st_d.acc  = alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = ctrl.sel_ir ? ir_q[ADDR_W-1:0] : pc_q;
    assign mem_rd    = ctrl.rd;
    assign mem_wr    = ctrl.wr;
    assign mem_wdata = ctrl.wr ? acc_q : '0;
    assign acc_out   = acc_q;
    assign acc_zero  = (acc_q == '0);

endmodule

// File: rtl/ocp_core_chk.sv
`timescale 1ns/1ps
module ocp_core_chk
    import ocp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata
);

    logic [OP_W-1:0] opc;
    logic            late_phase;
    assign opc        = ir[DATA_W-1:DATA_W-OP_W];
    assign late_phase = (phase == PH_ADDR) || (phase == PH_OPRD)
                     || (phase == PH_EXEC) || (phase == PH_WRB);

    assert_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(phase ^ $past(phase)) == 1));

    assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRB) |=> (phase == PH_IDLE));

    assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |-> (mem_rd && mem_addr == pc));

    assert_no_rdwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (phase == PH_FETCH || phase == PH_OPRD));

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_STEP && !(phase == PH_OPRD && opc == 3'd7)) |=> $stable(pc));

    assert_opnd_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        late_phase |-> (mem_addr == ir[ADDR_W-1:0]));

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_EXEC) |=> $stable(acc));

    assert_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPRD && opc == 3'd7) |=> (pc == $past(ir[ADDR_W-1:0])));

    assert_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (phase == PH_WRB && mem_wdata == acc));

endmodule

bind ocp_core ocp_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_q),
    .pc        (pc_q),
    .ir        (ir_q),
    .acc       (acc_q),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_ocp_core.sv
`timescale 1ns/1ps
module tb_ocp_core;

    localparam int DW      = 8;
    localparam int AW      = 5;
    localparam int DEPTH   = 1 << AW;
    localparam int N_INSTR = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata, acc_out;
    logic          acc_zero;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [DEPTH];

    typedef struct {
        logic [AW-1:0] pc;
        logic          after_jump;
        logic [AW-1:0] opa;
        logic          rd_op;
        logic          st;
        logic [DW-1:0] st_d;
        logic [DW-1:0] acc;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    ocp_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .acc_zero(acc_zero)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Loads the program and predicts every instruction from the requirements
    task automatic drive_program();
        logic [DW-1:0] rm [DEPTH];
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        logic          jmp;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        mem[5'h00] = 8'hB8;  // load  18
        mem[5'h01] = 8'h59;  // add   19
        mem[5'h02] = 8'h20;  // inc
        mem[5'h03] = 8'h60;  // not
        mem[5'h04] = 8'h9A;  // xor   1A
        mem[5'h05] = 8'hDB;  // store 1B
        mem[5'h06] = 8'h00;  // nop
        mem[5'h07] = 8'hBB;  // load  1B
        mem[5'h08] = 8'h5C;  // add   1C (wraps)
        mem[5'h09] = 8'hFE;  // jump  1E
        mem[5'h18] = 8'h33;
        mem[5'h19] = 8'hCC;
        mem[5'h1A] = 8'h0F;
        mem[5'h1C] = 8'h20;
        mem[5'h1E] = 8'hDD;  // store 1D
        mem[5'h1F] = 8'h20;  // inc, then PC wraps to 00
        for (int i = 0; i < DEPTH; i++) rm[i] = mem[i];
        pc = '0; acc = '0; jmp = 1'b0;
        for (int n = 0; n < N_INSTR; n++) begin
            exp_t e;
            logic [DW-1:0] w;
            logic [2:0]    o;
            logic [AW-1:0] a;
            w = rm[pc]; o = w[7:5]; a = w[4:0];
            e.pc = pc; e.after_jump = jmp; e.opa = a;
            e.rd_op = (o == 3'd2 || o == 3'd4 || o == 3'd5);
            e.st = (o == 3'd6); e.st_d = e.st ? acc : 8'h00;
            pc = pc + 1'b1; jmp = 1'b0;
            case (o)
                3'd1: acc = acc + 8'd1;
                3'd2: acc = acc + rm[a];
                3'd3: acc = ~acc;
                3'd4: acc = acc ^ rm[a];
                3'd5: acc = rm[a];
                3'd6: rm[a] = acc;
                3'd7: begin pc = a; jmp = 1'b1; end
                default: ;
            endcase
            e.acc = acc;
            sb.push_back(e);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        drive_program();
        #7;
        // R2: reset state
        chk("R2 addr", 16'(mem_addr), 16'h0);
        chk("R2 rd",   16'(mem_rd),   16'h0);
        chk("R2 wr",   16'(mem_wr),   16'h0);
        chk("R2 acc",  16'(acc_out),  16'h0);
        chk("R10 zero at reset", 16'(acc_zero), 16'h1);
        @(negedge clk) rst_n = 1'b1;
        // monitor: pops one predicted item per eight-clock frame (R1 timing)
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            for (int s = 1; s <= 8; s++) begin
                @(posedge clk); #1;
                case (s)
                    1: begin
                        chk("R3 fetch strobe", 16'(mem_rd), 16'h1);
                        chk(e.after_jump ? "R8 fetch at jump target" : "R5 fetch at PC",
                            16'(mem_addr), 16'(e.pc));
                        chk("R9 no write", 16'(mem_wr), 16'h0);
                    end
                    2: chk("R4 read dropped", 16'(mem_rd), 16'h0);
                    4: chk("R6 operand address", 16'(mem_addr), 16'(e.opa));
                    5: begin
                        chk("R4 operand read", 16'(mem_rd), 16'(e.rd_op));
                        chk("R6 operand address", 16'(mem_addr), 16'(e.opa));
                    end
                    7: begin
                        chk("R9 write strobe", 16'(mem_wr), 16'(e.st));
                        chk("R9 write data", 16'(mem_wdata), 16'(e.st_d));
                        if (e.st) chk("R9 write address", 16'(mem_addr), 16'(e.opa));
                    end
                    8: begin
                        chk("R7 accumulator", 16'(acc_out), 16'(e.acc));
                        chk("R10 zero flag", 16'(acc_zero), 16'(e.acc == 8'h00));
                    end
                    default: ;
                endcase
            end
        end
        chk("R9 stored 1B", 16'(mem[5'h1B]), 16'hF0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule